// File: doc/BRIEF.md
# Interrupt Countdown Timer

A memory-mapped down-counter that signals an interrupt request tagged with a programmable 8-bit vector when its count runs out. Software programs a vector-table entry (vector, mask, one-shot or periodic mode, count clock source), picks a prescale ratio, and starts the timer by writing an initial count. The running value can be read back at any time.

The count clock is the raw block clock, an external timebase strobe, or a prescaler output that divides the block clock by 1 to 128. The prescale ratio is chosen by a four-bit code whose mapping is not linear. On expiry the block issues a single-cycle request pulse that carries the vector. In periodic mode the counter then reloads itself; in one-shot mode it stops at zero. Prioritisation, in-service tracking and acknowledge handling belong to other blocks.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the vector-table entry reads 0x0001_0000 (mask set, everything else zero). The initial count, current count and divide code read zero, and no request is raised.
- R2: Registers sit at word addresses 0xC8 (vector-table entry), 0xE0 (initial count), 0xE4 (current count) and 0xF8 (divide code). The vector-table entry reads back bits [19:18] clock base, [17] mode, [16] mask and [7:0] vector, with all other bits zero. Any other address reads zero.
- R3: A write of a nonzero value N to the initial count loads the current count with N in the same edge. The count then falls by one per count tick.
- R4: When the count goes from 1 to 0, `irq_pulse` is high for exactly one cycle, starting the cycle after that edge, and `irq_vector` carries bits [7:0] of the vector-table entry.
- R5: Periodic mode (bit 17 = 1): on the first tick after reaching zero the counter reloads the initial count, so expiries repeat every N+1 ticks. One-shot mode (bit 17 = 0): it stays at zero and raises no further request.
- R6: With the mask (bit 16) set, expiry raises no request, but reloading and stopping happen as in R5.
- R7: Writing zero to the initial count stops the timer at once with a current count of zero, and no request follows.
- R8: Clock base 00 gives one tick per clock cycle. The unused base code 11 behaves the same.
- R9: Clock base 01 gives one tick for each cycle in which `ext_tick` is high.
- R10: Clock base 10 gives one tick every D cycles, with divide codes 0x0→2, 0x1→4, 0x2→8, 0x3→16, 0x8→32, 0x9→64, 0xA→128 and 0xB→1. The prescaler restarts on every write to the initial count or the divide code, so with base 10 the first expiry is N·D cycles after the initial-count write.
- R11: Only bits 3, 1 and 0 of the divide code are stored. Writing 0xF reads back 0xB. Writing 0x7 reads back 0x3 and divides by 16.
- R12: Writes to the current-count address are ignored.
- R13: `irq_vector` is zero whenever `irq_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_tick | input | 1 | Timebase strobe used when clock base is 01 |
| req_we | input | 1 | Write strobe for the register port |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data for `req_addr`, combinational |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
A write takes effect at the clock edge that samples it. Read data follows the address within the same cycle, so register values are checked one half-cycle after the write edge. The request pulse is registered, so it is expected N·D edges after the initial-count write, and in periodic mode again (2N+1)·D edges after it. The bench counts edges from the write and samples the pulse on every falling edge. It records the first and second expiry cycle and the total pulse count, and compares them with those products for every divide code, both modes and several counts. Timebase ticks are driven on the falling edge, so each one lands on exactly one rising edge.

// File: rtl/irqtmr_pkg.sv
package irqtmr_pkg;

   localparam int unsigned WORD_W = 32;

   // word addresses; software depends on these
   localparam logic [7:0] ADR_LVT  = 8'hC8;
   localparam logic [7:0] ADR_INIT = 8'hE0;
   localparam logic [7:0] ADR_CUR  = 8'hE4;
   localparam logic [7:0] ADR_DIV  = 8'hF8;

   typedef enum logic [1:0] {
      BASE_RAW = 2'b00,
      BASE_EXT = 2'b01,
      BASE_DIV = 2'b10,
      BASE_ALT = 2'b11
   } base_e;

   typedef struct packed {
      base_e      base;
      logic       periodic;
      logic       masked;
      logic [7:0] vector;
   } lvt_t;

   // code = {reg bit3, reg bit1, reg bit0}; returns log2 of divide ratio
   function automatic logic [2:0] div_shift(input logic [2:0] code);
      if (!code[2])                return 3'(code[1:0]) + 3'd1;
      else if (code[1:0] == 2'b11) return 3'd0;
      else                         return 3'(code[1:0]) + 3'd5;
   endfunction

endpackage

// File: rtl/irqtmr_regs.sv
module irqtmr_regs
   import irqtmr_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [31:0]       wdata_i,
   input  logic [CNT_W-1:0]  cur_cnt_i,
   output logic [31:0]       rdata_o,
   output lvt_t              lvt_o,
   output logic [CNT_W-1:0]  init_cnt_o,
   output logic [2:0]        div_code_o,
   output logic              init_we_o,
   output logic              div_we_o
);

   localparam logic [ADDR_W-1:0] A_LVT  = ADDR_W'(ADR_LVT);
   localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(ADR_INIT);
   localparam logic [ADDR_W-1:0] A_CUR  = ADDR_W'(ADR_CUR);
   localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(ADR_DIV);

   lvt_t             lvt_q;
   logic [CNT_W-1:0] init_q;
   logic [2:0]       div_q;
   logic             lvt_we;

   assign lvt_we    = we_i && (addr_i == A_LVT);
   assign init_we_o = we_i && (addr_i == A_INIT);
   assign div_we_o  = we_i && (addr_i == A_DIV);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvt_q.base     <= BASE_RAW;
         lvt_q.periodic <= 1'b0;
         lvt_q.masked   <= 1'b1;
         lvt_q.vector   <= 8'h00;
         init_q         <= '0;
         div_q          <= 3'b000;
      end else begin
         if (lvt_we) begin
            lvt_q.base     <= base_e'(wdata_i[19:18]);
            lvt_q.periodic <= wdata_i[17];
            lvt_q.masked   <= wdata_i[16];
            lvt_q.vector   <= wdata_i[7:0];
         end
         if (init_we_o) init_q <= wdata_i[CNT_W-1:0];
         if (div_we_o)  div_q  <= {wdata_i[3], wdata_i[1:0]};
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_LVT:  rdata_o = {12'h000, lvt_q.base, lvt_q.periodic, lvt_q.masked,
                            8'h00, lvt_q.vector};
         A_INIT: rdata_o = WORD_W'(init_q);
         A_CUR:  rdata_o = WORD_W'(cur_cnt_i);
         A_DIV:  rdata_o = {28'h0, div_q[2], 1'b0, div_q[1:0]};
         default: rdata_o = '0;
      endcase
   end

   assign lvt_o      = lvt_q;
   assign init_cnt_o = init_q;
   assign div_code_o = div_q;

   // R11
   div_bit2_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == A_DIV) |-> (rdata_o[2] == 1'b0 && rdata_o[31:4] == '0));

endmodule

// File: rtl/irqtmr_tickgen.sv
module irqtmr_tickgen
   import irqtmr_pkg::*;
#(
   parameter int SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart_i,
   input  logic [2:0] div_code_i,
   input  base_e      base_i,
   input  logic       ext_tick_i,
   output logic       tick_o
);

   localparam int PRE_W = 7;

   logic             ext_s;
   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] pre_last;
   logic             pre_hit;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign ext_s = ext_tick_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= (sh_q << 1) | SYNC_STAGES'(ext_tick_i);
         end
         assign ext_s = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   assign pre_last = PRE_W'((8'd1 << div_shift(div_code_i)) - 8'd1);
   assign pre_hit  = (pre_q == pre_last);

   always_ff @(posedge clk) begin
      if (!rst_n)                  pre_q <= '0;
      else if (restart_i || pre_hit) pre_q <= '0;
      else                         pre_q <= pre_q + 1'b1;
   end

   always_comb begin
      unique case (base_i)
         BASE_EXT: tick_o = ext_s;
         BASE_DIV: tick_o = pre_hit;
         default:  tick_o = 1'b1;
      endcase
   end

   // R10
   pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= pre_last || $past(pre_q) != pre_q - 1'b1);

endmodule

// File: rtl/irqtmr_counter.sv
module irqtmr_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic [CNT_W-1:0] init_i,
   input  logic             tick_i,
   input  logic             periodic_i,
   input  logic             masked_i,
   input  logic [7:0]       vector_i,
   output logic [CNT_W-1:0] cur_o,
   output logic             irq_o,
   output logic [7:0]       irq_vec_o
);

   logic [CNT_W-1:0] cur_q;
   logic             run_q;
   logic             expire;

   assign expire = run_q && tick_i && !load_i && (cur_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q     <= '0;
         run_q     <= 1'b0;
         irq_o     <= 1'b0;
         irq_vec_o <= 8'h00;
      end else begin
         irq_o     <= expire && !masked_i;
         irq_vec_o <= (expire && !masked_i) ? vector_i : 8'h00;
         if (load_i) begin
            cur_q <= load_val_i;
            run_q <= (load_val_i != '0);
         end else if (run_q && tick_i) begin
            if (cur_q == '0) begin
               cur_q <= init_i;
            end else begin
               cur_q <= cur_q - 1'b1;
               if (expire && !periodic_i) run_q <= 1'b0;
            end
         end
      end
   end

   assign cur_o = cur_q;

   // R4
   irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (cur_q == '0));

   // R4
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   // R3
   cur_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(load_i)) |->
         (cur_q == $past(cur_q) || cur_q == $past(cur_q) - 1'b1 ||
          ($past(cur_q) == '0 && cur_q == $past(init_i))));

   // R7
   stop_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(load_i) && $past(load_val_i) == '0) |->
         (cur_q == '0 && !run_q));

   // R13
   vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> (irq_vec_o == 8'h00));

endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
   import irqtmr_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_tick,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic [31:0]       req_rdata,
   output logic              irq_pulse,
   output logic [7:0]        irq_vector
);

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must be at least 8");
      end
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 2..32");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   lvt_t             lvt;
   logic [CNT_W-1:0] init_cnt;
   logic [CNT_W-1:0] cur_cnt;
   logic [2:0]       div_code;
   logic             init_we;
   logic             div_we;
   logic             tick;

   irqtmr_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_i      (req_we),
      .addr_i    (req_addr),
      .wdata_i   (req_wdata),
      .cur_cnt_i (cur_cnt),
      .rdata_o   (req_rdata),
      .lvt_o     (lvt),
      .init_cnt_o(init_cnt),
      .div_code_o(div_code),
      .init_we_o (init_we),
      .div_we_o  (div_we)
   );

   irqtmr_tickgen #(.SYNC_STAGES(SYNC_STAGES)) u_tickgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (init_we || div_we),
      .div_code_i(div_code),
      .base_i    (lvt.base),
      .ext_tick_i(ext_tick),
      .tick_o    (tick)
   );

   irqtmr_counter #(.CNT_W(CNT_W)) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (init_we),
      .load_val_i(req_wdata[CNT_W-1:0]),
      .init_i    (init_cnt),
      .tick_i    (tick),
      .periodic_i(lvt.periodic),
      .masked_i  (lvt.masked),
      .vector_i  (lvt.vector),
      .cur_o     (cur_cnt),
      .irq_o     (irq_pulse),
      .irq_vec_o (irq_vector)
   );

   // R6
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> !$past(lvt.masked));

endmodule

// File: tb/irq_countdown_timer_bench.sv
`timescale 1ns/1ps
module irq_countdown_timer_bench;

   localparam logic [7:0] T_LVT = 8'hC8, T_INIT = 8'hE0, T_CUR = 8'hE4, T_DIV = 8'hF8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_tick = 1'b0;
   logic        req_we = 1'b0;
   logic [7:0]  req_addr = 8'h00;
   logic [31:0] req_wdata = 32'h0;
   logic [31:0] req_rdata;
   logic        irq_pulse;
   logic [7:0]  irq_vector;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_countdown_timer u_irq_countdown_timer (
      .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
      .irq_pulse(irq_pulse), .irq_vector(irq_vector)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      req_we = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      req_addr = a;
      #1;
      d = req_rdata;
   endtask

   task automatic watch(input int lim, output int first, output int second,
                        output int hits, output logic [7:0] v);
      first = -1; second = -1; hits = 0; v = 8'h00;
      for (int j = 1; j <= lim; j++) begin
         @(negedge clk);
         if (irq_pulse) begin
            hits++;
            if (first < 0) begin first = j; v = irq_vector; end
            else if (second < 0) second = j;
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      int f, s, h;
      logic [7:0] v;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(T_LVT, r);  check("R1 lvt", r, 32'h0001_0000);
      rd(T_INIT, r); check("R1 init", r, 32'h0);
      rd(T_CUR, r);  check("R1 cur", r, 32'h0);
      rd(T_DIV, r);  check("R1 div", r, 32'h0);
      check("R1 irq", {31'h0, irq_pulse}, 32'h0);

      // R2 readback and unmapped address
      wr(T_LVT, 32'hFFFF_FFFF);
      rd(T_LVT, r); check("R2 lvt fields", r, 32'h000F_00FF);
      rd(8'h00, r); check("R2 unmapped", r, 32'h0);
      wr(T_INIT, 32'h1234_5678);
      rd(T_INIT, r); check("R2 init readback", r, 32'h1234_5678);
      wr(T_INIT, 32'h0);

      // R11 divide code storage
      wr(T_DIV, 32'hF); rd(T_DIV, r); check("R11 div 0xF", r, 32'hB);
      wr(T_DIV, 32'h7); rd(T_DIV, r); check("R11 div 0x7", r, 32'h3);
      wr(T_LVT, 32'h0008_0011);
      wr(T_INIT, 32'd2);
      watch(40, f, s, h, v);
      check("R11 div16 first expiry", 32'(f), 32'd32);
      check("R11 div16 one pulse", 32'(h), 32'd1);

      // R10 R4 R5 R13 sweep over divide codes, modes and counts
      for (int m = 0; m < 2; m++) begin
         for (int ci = 0; ci < 8; ci++) begin
            for (int n = 1; n <= 3; n++) begin : sweep
               logic [3:0] code;
               int d;
               logic [7:0] vec;
               code = (ci < 4) ? 4'(ci) : 4'(ci + 4);
               d = code[3] ? ((code[1:0] == 2'b11) ? 1 : (1 << (code[1:0] + 5)))
                           : (1 << (code[1:0] + 1));
               vec = 8'(64 + ci * 4 + n);
               wr(T_INIT, 32'h0);
               wr(T_DIV, {28'h0, code});
               wr(T_LVT, {12'h0, 2'b10, 1'(m), 1'b0, 8'h00, vec});
               wr(T_INIT, 32'(n));
               watch((2 * n + 1) * d + 1, f, s, h, v);
               check("R10 first expiry cycle", 32'(f), 32'(n * d));
               check("R4 vector", {24'h0, v}, {24'h0, vec});
               if (m == 1) begin
                  check("R5 periodic second expiry", 32'(s), 32'((2 * n + 1) * d));
                  check("R5 periodic pulse count", 32'(h), 32'd2);
               end else begin
                  check("R5 one-shot pulse count", 32'(h), 32'd1);
                  rd(T_CUR, r); check("R5 one-shot holds zero", r, 32'h0);
               end
               check("R13 idle vector", {24'h0, irq_vector}, 32'h0);
            end
         end
      end

      // R6 masked periodic still reloads
      wr(T_INIT, 32'h0);
      wr(T_LVT, 32'h0003_0055);
      wr(T_INIT, 32'd2);
      watch(3, f, s, h, v);
      rd(T_CUR, r); check("R6 reload while masked", r, 32'd2);
      check("R6 no pulse", 32'(h), 32'd0);
      watch(20, f, s, h, v);
      check("R6 no pulse long", 32'(h), 32'd0);

      // R8 base 11 acts as raw clock
      wr(T_INIT, 32'h0);
      wr(T_LVT, 32'h000C_0033);
      wr(T_INIT, 32'd3);
      watch(10, f, s, h, v);
      check("R8 base11 expiry", 32'(f), 32'd3);
      check("R8 base11 pulses", 32'(h), 32'd1);
      check("R8 base11 vector", {24'h0, v}, 32'h33);

      // R3 R12 counting and ignored current-count write
      wr(T_LVT, 32'h0000_0011);
      wr(T_INIT, 32'd50);
      wr(T_CUR, 32'd77);
      rd(T_CUR, r); check("R12 cur write ignored", r, 32'd48);
      @(negedge clk);
      rd(T_CUR, r); check("R3 decrement per tick", r, 32'd47);

      // R7 stop by writing zero
      wr(T_INIT, 32'd5);
      @(negedge clk);
      wr(T_INIT, 32'd0);
      rd(T_CUR, r); check("R7 stopped count", r, 32'h0);
      watch(20, f, s, h, v);
      check("R7 no pulse after stop", 32'(h), 32'd0);

      // R9 external timebase
      wr(T_LVT, 32'h0004_0021);
      wr(T_INIT, 32'd3);
      repeat (5) @(negedge clk);
      rd(T_CUR, r); check("R9 no ext tick holds", r, 32'd3);
      for (int k = 0; k < 2; k++) begin
         @(negedge clk); ext_tick = 1'b1;
         @(negedge clk); ext_tick = 1'b0;
      end
      rd(T_CUR, r); check("R9 two ext ticks", r, 32'd1);
      @(negedge clk); ext_tick = 1'b1;
      @(negedge clk); ext_tick = 1'b0;
      check("R9 expiry on third tick", {31'h0, irq_pulse}, 32'd1);
      check("R9 vector", {24'h0, irq_vector}, 32'h21);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule